// File: doc/BRIEF.md
# Programmable-Edge Serial Master with Register Bus

This block is a serial peripheral interface master that software drives through a small 32-bit register window. Software first sets the serial clock divider, the select polarity and up to four transmit words. It then writes the control word with its go bit set. The block asserts the select line and clocks out the programmed number of words while capturing the same number of words from the input pin. The go/busy bit reads back as 1 until the burst has finished. Each word is 1 to 32 bits long, and a burst holds 1 to 4 words. Software chooses which end of each word is shifted first. It also picks the serial clock edge that changes output data and, independently, the edge that samples input data.

The transfer is controlled by a four-state machine. IDLE moves to LOAD when an accepted control write carries go=1. LOAD, which lasts one cycle, presents the first output bit under the newly written settings and moves unconditionally to SHIFT. SHIFT runs the serial clock and moves to TAIL on the falling serial clock edge that ends the last bit of the last word. TAIL, which lasts one cycle, moves unconditionally back to IDLE. The bus is busy in LOAD, SHIFT and TAIL.

Each data offset is shared. A read returns the receive word captured at that offset, and a write loads the transmit word at that offset.

Top module: `spi_ctl_host`

## Requirements
- R1: After reset, control (offset 0x00) reads 0x0000_0004, and the divider (0x04), select (0x08), the unused offset 0x0C and the four data offsets 0x10/0x14/0x18/0x1C read 0.
- R2: At data offset 0x10+4n, a write loads transmit word n and a read returns receive word n. When a burst starts, all receive words clear to 0, so bits and words that the burst does not fill read 0.
- R3: A control write with bit 0 set starts a burst. Bit 0 reads 1 from the accepted write until the burst ends, then reads 0. While busy, every register write is ignored, including a control write with bit 0 set.
- R4: The serial clock idles low. During a burst its period is 2*(D+1) system clocks, where D is the divider register value, and each period starts with its low half.
- R5: Control bits [7:3] set the word length in bits, and the value 0 means 32. A burst produces word length × word count rising serial clock edges.
- R6: Control bits [9:8] hold the word count minus one, so the value 0 means one word. Words are sent and received in order 0, 1, 2, 3.
- R7: Control bit 10 set makes bit 0 of each word go first on both output and input. Clear means the top bit of the word length goes first.
- R8: Control bit 2 (reset value 1) selects the output edge. With 1, output data changes on falling serial clock edges and the first bit is valid before the first rising edge. With 0, output data changes on rising edges.
- R9: Control bit 1 selects the input sample edge: 0 samples on rising serial clock edges, 1 on falling edges.
- R10: Bit 0 of the select register sets the active level of the select output (0 means active low). The select output is at that level exactly while busy and at the opposite level otherwise.
- R11: Busy and select both release one system clock after the final falling serial clock edge of the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe for the register at bus_addr |
| bus_addr | input | ADDR_W (5) | Byte offset of the register; the low two bits must be 0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| spi_ss | output | 1 | Slave select, polarity from the select register |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
Assertions check on every cycle that the serial clock is low and the select line is inactive whenever the block is not busy, and that a start pulse reaches the engine only in IDLE. They also check that the control fields and the divider count stay frozen while busy, that the bit and word counters stay inside the programmed burst, and that busy falls exactly two cycles after the final falling edge strobe. Only the bench scenarios can show the serialised data itself: bit order, which edge launches and which samples, word length, word count and masking, the measured clock period, and that writes made while busy leave both the configuration and the transmit data untouched.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
    localparam int WORD_W = 32;
    localparam int NWORDS = 4;
    localparam int LENF_W = $clog2(WORD_W);
    localparam int LEN_W  = LENF_W + 1;
    localparam int WIDX_W = $clog2(NWORDS);

    localparam int CTL_GO  = 0;
    localparam int CTL_LSB = 1 + 2 + LENF_W + WIDX_W;

    // packed order matches control bits [CTL_LSB:1]
    typedef struct packed {
        logic              lsb;
        logic [WIDX_W-1:0] last_word;
        logic [LENF_W-1:0] len_code;
        logic              tx_fall;
        logic              rx_fall;
    } xfer_cfg_t;

    localparam xfer_cfg_t CFG_RESET = '{lsb: 1'b0, last_word: '0, len_code: '0,
                                        tx_fall: 1'b1, rx_fall: 1'b0};

    typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT, ST_TAIL} xfer_state_t;
endpackage

// File: rtl/spi_ctl_regs.sv
module spi_ctl_regs
    import spi_ctl_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DIV_W  = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_wr,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [31:0]                    bus_wdata,
    output logic [31:0]                    bus_rdata,
    input  logic                           busy,
    input  logic [NWORDS-1:0][WORD_W-1:0]  rx_words,
    output xfer_cfg_t                      cfg,
    output logic [DIV_W-1:0]               div,
    output logic                           ss_lvl,
    output logic [NWORDS-1:0][WORD_W-1:0]  tx_words,
    output logic                           start
);
    localparam int IDX_W     = ADDR_W - 2;
    localparam int DATA_BASE = 4;

    logic [IDX_W-1:0] idx;
    logic             hit;
    logic             wr_ok;

    assign idx   = bus_addr[ADDR_W-1:2];
    assign hit   = (bus_addr[1:0] == 2'b00);
    assign wr_ok = bus_wr && hit && !busy;
    assign start = wr_ok && (idx == '0) && bus_wdata[CTL_GO];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg      <= CFG_RESET;
            div      <= '0;
            ss_lvl   <= 1'b0;
            tx_words <= '0;
        end else if (wr_ok) begin
            if (idx == IDX_W'(0)) cfg    <= bus_wdata[CTL_LSB:1];
            if (idx == IDX_W'(1)) div    <= bus_wdata[DIV_W-1:0];
            if (idx == IDX_W'(2)) ss_lvl <= bus_wdata[0];
            for (int n = 0; n < NWORDS; n++) begin
                if (idx == IDX_W'(DATA_BASE + n)) tx_words[n] <= bus_wdata;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            if (idx == IDX_W'(0)) bus_rdata[CTL_LSB:0] = {cfg, busy};
            if (idx == IDX_W'(1)) bus_rdata[DIV_W-1:0] = div;
            if (idx == IDX_W'(2)) bus_rdata[0]         = ss_lvl;
            for (int n = 0; n < NWORDS; n++) begin
                if (idx == IDX_W'(DATA_BASE + n)) bus_rdata = rx_words[n];
            end
        end
    end

    // R3: configuration cannot move under a running burst
    p_cfg_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(cfg) && $stable(div) && $stable(ss_lvl)));
endmodule

// File: rtl/spi_ctl_clkgen.sv
module spi_ctl_clkgen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             sclk,
    output logic             rise_stb,
    output logic             fall_stb
);
    logic [DIV_W-1:0] cnt_q;
    logic             half_end;

    assign half_end = run && (cnt_q == div);
    assign rise_stb = half_end && !sclk;
    assign fall_stb = half_end && sclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sclk  <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            sclk  <= 1'b0;
        end else if (half_end) begin
            cnt_q <= '0;
            sclk  <= !sclk;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    // R4: every burst opens with a low half period
    p_low_at_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> !sclk);
    // R4: half-period counter never runs past the divider
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= div));
endmodule

// File: rtl/spi_ctl_engine.sv
module spi_ctl_engine
    import spi_ctl_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  xfer_cfg_t                      cfg,
    input  logic                           ss_lvl,
    input  logic [NWORDS-1:0][WORD_W-1:0]  tx_words,
    input  logic                           rise_stb,
    input  logic                           fall_stb,
    input  logic                           miso,
    output logic                           run,
    output logic                           busy,
    output logic                           ss,
    output logic                           mosi,
    output logic [NWORDS-1:0][WORD_W-1:0]  rx_words
);
    xfer_state_t       state_q, state_d;
    logic [LEN_W-1:0]  len, bit_q, bit_nx;
    logic [WIDX_W-1:0] word_q, word_nx;
    logic              last_bit, last_word, launch, capture;

    function automatic logic [LENF_W-1:0] bit_pos(input logic lsb_first,
                                                  input logic [LEN_W-1:0] length,
                                                  input logic [LEN_W-1:0] b);
        logic [LEN_W-1:0] mirrored;
        mirrored = length - LEN_W'(1) - b;
        return lsb_first ? b[LENF_W-1:0] : mirrored[LENF_W-1:0];
    endfunction

    assign len       = (cfg.len_code == '0) ? LEN_W'(WORD_W) : {1'b0, cfg.len_code};
    assign last_bit  = (bit_q == len - LEN_W'(1));
    assign last_word = (word_q == cfg.last_word);
    assign bit_nx    = last_bit ? '0 : bit_q + LEN_W'(1);
    assign word_nx   = last_bit ? word_q + WIDX_W'(1) : word_q;
    assign launch    = cfg.tx_fall ? (fall_stb && !(last_bit && last_word)) : rise_stb;
    assign capture   = cfg.rx_fall ? fall_stb : rise_stb;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_LOAD;
            ST_LOAD:  state_d = ST_SHIFT;
            ST_SHIFT: if (fall_stb && last_bit && last_word) state_d = ST_TAIL;
            ST_TAIL:  state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        busy = (state_q != ST_IDLE);
        run  = (state_q == ST_SHIFT);
        ss   = busy ? ss_lvl : !ss_lvl;
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q    <= '0;
            word_q   <= '0;
            mosi     <= 1'b0;
            rx_words <= '0;
        end else if (state_q == ST_LOAD) begin
            bit_q    <= '0;
            word_q   <= '0;
            mosi     <= tx_words[0][bit_pos(cfg.lsb, len, '0)];
            rx_words <= '0;
        end else if (state_q == ST_SHIFT) begin
            if (launch) begin
                mosi <= cfg.tx_fall ? tx_words[word_nx][bit_pos(cfg.lsb, len, bit_nx)]
                                    : tx_words[word_q][bit_pos(cfg.lsb, len, bit_q)];
            end
            if (capture) rx_words[word_q][bit_pos(cfg.lsb, len, bit_q)] <= miso;
            if (fall_stb) begin
                bit_q  <= bit_nx;
                word_q <= word_nx;
            end
        end
    end

    // R3: the register file only forwards a start when the engine is idle
    p_start_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (state_q == ST_IDLE));
    // R5: bit counter stays inside the programmed word length
    p_bit_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT) |-> (bit_q < len));
    // R6: word counter stays inside the programmed burst
    p_word_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT) |-> (word_q <= cfg.last_word));
    // R11: busy drops two cycles after the final falling strobe
    p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(fall_stb, 2));
endmodule

// File: rtl/spi_ctl_host.sv
module spi_ctl_host
    import spi_ctl_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              spi_ss,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    xfer_cfg_t                     cfg;
    logic [DIV_W-1:0]              div;
    logic                          ss_lvl, start, busy, run, rise_stb, fall_stb;
    logic [NWORDS-1:0][WORD_W-1:0] tx_words, rx_words;

    spi_ctl_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
        .rx_words(rx_words), .cfg(cfg), .div(div), .ss_lvl(ss_lvl),
        .tx_words(tx_words), .start(start)
    );

    spi_ctl_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .run(run), .div(div),
        .sclk(spi_sclk), .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    spi_ctl_engine u_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg(cfg), .ss_lvl(ss_lvl),
        .tx_words(tx_words), .rise_stb(rise_stb), .fall_stb(fall_stb),
        .miso(spi_miso), .run(run), .busy(busy), .ss(spi_ss),
        .mosi(spi_mosi), .rx_words(rx_words)
    );

    // R4: serial clock is parked low outside a burst
    p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !spi_sclk);
    // R10: select sits at its inactive level outside a burst
    p_ss_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (spi_ss == !ss_lvl));
endmodule

// File: tb/spi_ctl_host_bench.sv
`timescale 1ns/1ps
module spi_ctl_host_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_ss, spi_sclk, spi_mosi;
    logic        spi_miso = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    // slave model state
    int          s_len = 8, s_nw = 1, rise_cnt = 0, fall_cnt = 0, per_bad = 0, ss_bad = 0;
    bit          s_lsb = 0, s_txf = 1, s_rxf = 0, s_on = 0, s_lvl = 0;
    logic [31:0] s_rx [4];
    logic [31:0] s_got [4];
    time         last_rise = 0, per_exp = 20;

    spi_ctl_host u_spi_ctl_host (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_ss(spi_ss),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always #5 clk = ~clk;

    function automatic int pos_of(int k);
        int b;
        b = k % s_len;
        return s_lsb ? b : s_len - 1 - b;
    endfunction

    function automatic logic mbit(int k);
        if (k >= s_len * s_nw) return 1'b0;
        return s_rx[k / s_len][pos_of(k)];
    endfunction

    always @(posedge spi_sclk) begin : rise_side
        int k;
        if (s_on) begin
            k = rise_cnt;
            rise_cnt++;
            if (k > 0 && ($time - last_rise) != per_exp) per_bad++;
            last_rise = $time;
            if (spi_ss !== s_lvl) ss_bad++;
            if (s_txf && k < s_len * s_nw) s_got[k / s_len][pos_of(k)] = spi_mosi;
            if (s_rxf) begin
                #1 spi_miso = mbit(k);
            end
        end
    end

    always @(negedge spi_sclk) begin : fall_side
        int k;
        if (s_on) begin
            k = fall_cnt;
            fall_cnt++;
            if (!s_txf && k < s_len * s_nw) s_got[k / s_len][pos_of(k)] = spi_mosi;
            if (!s_rxf) begin
                #1 spi_miso = mbit(k + 1);
            end
        end
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bus_read(5'h00, d); chk(d == 32'h4, "R1 control reset", d, 32'h4);
        bus_read(5'h04, d); chk(d == 0, "R1 divider reset", d, 0);
        bus_read(5'h08, d); chk(d == 0, "R1 select reset", d, 0);
        bus_read(5'h0C, d); chk(d == 0, "R1 unused offset", d, 0);
        for (int n = 0; n < 4; n++) begin
            bus_read(5'(16 + 4 * n), d); chk(d == 0, "R1 R2 receive word reset", d, 0);
        end
        chk(spi_ss == 1'b1 && spi_sclk == 1'b0, "R10 R4 idle pins after reset",
            {30'b0, spi_ss, spi_sclk}, 32'h2);
    endtask

    task automatic run_xfer(input int lenf, input int nwf, input bit lsb, input bit txf,
                            input bit rxf, input int dv, input bit lvl,
                            input logic [31:0] t0, input logic [31:0] t1,
                            input logic [31:0] t2, input logic [31:0] t3,
                            input logic [31:0] r0, input logic [31:0] r1,
                            input logic [31:0] r2, input logic [31:0] r3,
                            input bit poke, input string tag);
        logic [31:0] d, ctl, mask;
        logic [31:0] tw [4];
        int n;
        tw[0] = t0; tw[1] = t1; tw[2] = t2; tw[3] = t3;
        s_rx[0] = r0; s_rx[1] = r1; s_rx[2] = r2; s_rx[3] = r3;
        s_len = (lenf == 0) ? 32 : lenf;
        s_nw = nwf + 1; s_lsb = lsb; s_txf = txf; s_rxf = rxf; s_lvl = lvl;
        n = s_len * s_nw;
        mask = (s_len == 32) ? 32'hFFFF_FFFF : ((32'h1 << s_len) - 32'h1);
        bus_write(5'h04, 32'(dv));
        bus_write(5'h08, {31'b0, lvl});
        for (int w = 0; w < 4; w++) bus_write(5'(16 + 4 * w), tw[w]);
        for (int w = 0; w < 4; w++) s_got[w] = '0;
        rise_cnt = 0; fall_cnt = 0; per_bad = 0; ss_bad = 0;
        per_exp = 2 * (dv + 1) * 10;
        spi_miso = mbit(0);
        s_on = 1;
        ctl = (32'(lsb) << 10) | (32'(nwf) << 8) | (32'(lenf) << 3) |
              (32'(txf) << 2) | (32'(rxf) << 1) | 32'h1;
        bus_write(5'h00, ctl);
        bus_read(5'h00, d);
        chk(d == ctl, {tag, " R3 busy bit reads 1 with fields"}, d, ctl);
        if (poke) begin
            bus_write(5'h00, 32'h0000_0139);
            bus_write(5'h10, 32'hDEAD_BEEF);
            bus_write(5'h04, 32'h0000_0007);
            bus_read(5'h00, d);
            chk(d == ctl, "R3 control write while busy ignored", d, ctl);
            bus_read(5'h04, d);
            chk(d == 32'(dv), "R3 divider write while busy ignored", d, 32'(dv));
            bus_read(5'h00, d);
        end
        wait (fall_cnt == n);
        #5;
        chk(bus_rdata[0] == 1'b1 && spi_ss == lvl, {tag, " R11 busy and select held in closing cycle"},
            {30'b0, bus_rdata[0], spi_ss}, {30'b0, 1'b1, lvl});
        #10;
        chk(bus_rdata[0] == 1'b0 && spi_ss == !lvl && !spi_sclk,
            {tag, " R11 R10 busy and select released"},
            {29'b0, bus_rdata[0], spi_ss, spi_sclk}, {29'b0, 1'b0, !lvl, 1'b0});
        repeat (40) @(negedge clk);
        chk(rise_cnt == n, {tag, " R5 R6 rising edge count, no restart"}, 32'(rise_cnt), 32'(n));
        s_on = 0;
        chk(per_bad == 0, {tag, " R4 serial clock period"}, 32'(per_bad), 0);
        chk(ss_bad == 0, {tag, " R10 select active during burst"}, 32'(ss_bad), 0);
        bus_read(5'h00, d);
        chk(d == (ctl & ~32'h1), {tag, " R3 busy cleared, fields kept"}, d, ctl & ~32'h1);
        for (int w = 0; w < s_nw; w++)
            chk(s_got[w] == (tw[w] & mask), {tag, " R8 R7 transmitted word"}, s_got[w], tw[w] & mask);
        for (int w = 0; w < 4; w++) begin
            bus_read(5'(16 + 4 * w), d);
            if (w < s_nw)
                chk(d == (s_rx[w] & mask), {tag, " R9 R2 received word"}, d, s_rx[w] & mask);
            else
                chk(d == 0, {tag, " R2 R6 unused receive word cleared"}, d, 0);
        end
    endtask

    initial begin : watchdog
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        // MSB first, launch falling, sample rising, divider 1, active low
        run_xfer(8, 0, 0, 1, 0, 1, 0, 32'h0000_00A5, 0, 0, 0,
                 32'hFFFF_FF3C, 0, 0, 0, 0, "s1 R5 R8 R9");
        // four 12-bit words, LSB first, launch rising, sample falling, divider 0, active high
        run_xfer(12, 3, 1, 0, 1, 0, 1, 32'hFFFF_F123, 32'h0000_0ABC, 32'h1234_5F0F, 32'h0000_05A6,
                 32'hABCD_E9C3, 32'h0000_0777, 32'h0000_0F01, 32'h8000_0246, 0, "s2 R6 R7");
        // full 32-bit words, MSB first, both on rising, divider 2
        run_xfer(0, 1, 0, 0, 0, 2, 0, 32'h8000_0001, 32'hDEAD_BEEF, 0, 0,
                 32'hCAFE_F00D, 32'h1234_5678, 0, 0, 0, "s3 R5 length 32");
        // writes while busy must not touch anything
        run_xfer(8, 0, 1, 1, 1, 3, 0, 32'h0000_0096, 0, 0, 0,
                 32'h0000_00E1, 0, 0, 0, 1, "s4 R3 busy lockout");
        summary();
        $finish;
    end
endmodule